// File: doc/BRIEF.md
# Split Instruction/Data Address Translator

This block turns virtual addresses into physical addresses for a processor core. It has two independent lookup paths, one for instruction fetches and one for data accesses, and each can be served in the same cycle. Each path has its own direct-mapped table of 64 entries. An entry is a pair of 32-bit words. The tag word holds the virtual page number and a valid flag. The frame word holds the physical page frame and the permission bits. Pages are 8 KiB, so the low 13 address bits pass through untranslated. The table index is the low six bits of the virtual page number.

A lookup compares the stored page number and checks the valid flag. It then applies the permission bits for the current privilege level, supervisor or user. It returns the physical address and the rights granted, or it returns an exception class: a table miss or a page fault, for each side. On any fault the offending virtual address is captured in a fault-address register. When translation is switched off, every address maps to itself with full rights. Entries are loaded by software through a simple write port.

Top module: `split_tlb_xlat`

## Requirements
- R1: Reset clears every valid flag in both tables, zeroes all response outputs and the fault address. Any translated lookup after reset reports a miss.
- R2: A lookup strobe sampled at a clock edge produces its response, with the response-valid flag high, right after that edge. A cycle without a strobe leaves that side's response-valid flag low.
- R3: With `xlat_en` low, the physical address equals the virtual address. Read, write and execute are all granted, and the exception code is 0.
- R4: When the tag's page number (bits 31:13) differs from the virtual page number, the result is a miss. The code is 1 for the instruction side and 2 for the data side. Address and rights read as zero.
- R5: A tag whose bit 0 is clear is invalid and gives the same miss code as R4, even when its page number matches.
- R6: Execute right on the instruction side is frame-word bit 6 in supervisor mode and bit 7 in user mode. A fetch without it gives code 3 (instruction page fault).
- R7: On the data side, read and write rights are frame-word bits 6 and 7 in supervisor mode, and bits 8 and 9 in user mode. A read without read right, or a write without write right, gives code 4 (data page fault).
- R8: On a hit the physical address is frame-word bits 31:13 followed by virtual bits 12:0. The granted rights appear on the rights outputs and the code is 0.
- R9: Any fault loads the faulting virtual address into `fault_addr`. If both sides fault in the same cycle, the data address wins. Without a fault the register holds its value.
- R10: `cfg_sel` bit 1 picks the table (0 instruction, 1 data) and bit 0 picks the word (0 tag, 1 frame). The table index is virtual address bits 18:13.
- R11: The two sides work independently: both may be requested in one cycle, and each gives its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlat_en | input | 1 | Translation enable; low means identity mapping |
| sup_mode | input | 1 | 1 = supervisor, 0 = user privilege |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Bit 1 table (0 instr, 1 data), bit 0 word (0 tag, 1 frame) |
| cfg_idx | input | 6 | Entry index to write |
| cfg_wdata | input | 32 | Word to write |
| if_req | input | 1 | Instruction lookup strobe |
| if_vaddr | input | 32 | Instruction virtual address |
| dc_req | input | 1 | Data lookup strobe |
| dc_write | input | 1 | 1 = store, 0 = load |
| dc_vaddr | input | 32 | Data virtual address |
| if_rsp_valid | output | 1 | Instruction response present |
| if_paddr | output | 32 | Instruction physical address |
| if_exec_ok | output | 1 | Execute granted |
| if_exc | output | 3 | Instruction exception code (0 none, 1 miss, 3 page fault) |
| dc_rsp_valid | output | 1 | Data response present |
| dc_paddr | output | 32 | Data physical address |
| dc_read_ok | output | 1 | Read granted |
| dc_write_ok | output | 1 | Write granted |
| dc_exc | output | 3 | Data exception code (0 none, 2 miss, 4 page fault) |
| fault_addr | output | 32 | Last faulting virtual address |

## Verification
Every lookup result, on both sides, and the fault-address update are due one clock edge after the strobe is sampled. Table writes take effect at the edge that samples them. The bench drives inputs on the falling edge, waits for exactly one rising edge, and compares every output on the next falling edge. This catches an extra register stage or a missing one. The model computes the expected values from a copy of the written words before the edge, so a lookup never races a write.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    // exception classes presented per side
    typedef enum logic [2:0] {
        EXC_NONE  = 3'd0,
        EXC_IMISS = 3'd1,
        EXC_DMISS = 3'd2,
        EXC_IPF   = 3'd3,
        EXC_DPF   = 3'd4
    } tlb_exc_e;

    // permission bit positions in the frame word
    localparam int RB_SUP_RD = 6;
    localparam int RB_SUP_WR = 7;
    localparam int RB_USR_RD = 8;
    localparam int RB_USR_WR = 9;
    localparam int RB_SUP_EX = 6;
    localparam int RB_USR_EX = 7;

    // write-port select encoding
    localparam int SEL_SIDE_BIT = 1;   // 0 instruction, 1 data
    localparam int SEL_WORD_BIT = 0;   // 0 tag, 1 frame

endpackage

// File: rtl/tlbx_table.sv
module tlbx_table #(
    parameter int ENTRIES = 64,
    parameter int WORD_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_frame,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_tag,
    output logic [WORD_W-1:0] rd_frame
);

    logic [WORD_W-1:0]  tag_mem   [ENTRIES];
    logic [WORD_W-1:0]  frame_mem [ENTRIES];
    logic [ENTRIES-1:0] valid_d, valid_q;

    always_comb begin
        valid_d = valid_q;
        if (wr_en && !wr_frame) begin
            valid_d[wr_idx] = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_frame) frame_mem[wr_idx] <= wr_data;
            else          tag_mem[wr_idx]   <= wr_data;
        end
    end

    // valid flag lives in a reset register; the stored tag bit 0 is not used
    assign rd_tag   = {tag_mem[rd_idx][WORD_W-1:1], valid_q[rd_idx]};
    assign rd_frame = frame_mem[rd_idx];

endmodule

// File: rtl/tlbx_probe.sv
module tlbx_probe
    import tlbx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    parameter bit IS_CODE   = 1'b0,
    localparam int VPN_W    = ADDR_W - PAGE_BITS
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [VPN_W-1:0]  tag_vpn,
    input  logic              tag_valid,
    input  logic [VPN_W-1:0]  frame_pfn,
    input  logic [3:0]        perm,      // frame-word bits 9:6
    input  logic              sup,
    input  logic              is_write,
    output logic [ADDR_W-1:0] paddr,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              ex_ok,
    output tlb_exc_e          exc
);

    localparam int PB = RB_SUP_RD;  // base of the permission nibble

    logic     grant_r, grant_w, grant_x, denied;
    tlb_exc_e miss_code, fault_code;

    generate
        if (IS_CODE) begin : g_code
            logic unused_code_in;
            assign unused_code_in = is_write ^ perm[RB_USR_RD-PB] ^ perm[RB_USR_WR-PB];
            assign grant_x    = sup ? perm[RB_SUP_EX-PB] : perm[RB_USR_EX-PB];
            assign grant_r    = 1'b0;
            assign grant_w    = 1'b0;
            assign denied     = !grant_x;
            assign miss_code  = EXC_IMISS;
            assign fault_code = EXC_IPF;
        end else begin : g_data
            assign grant_r    = sup ? perm[RB_SUP_RD-PB] : perm[RB_USR_RD-PB];
            assign grant_w    = sup ? perm[RB_SUP_WR-PB] : perm[RB_USR_WR-PB];
            assign grant_x    = 1'b0;
            assign denied     = is_write ? !grant_w : !grant_r;
            assign miss_code  = EXC_DMISS;
            assign fault_code = EXC_DPF;
        end
    endgenerate

    always_comb begin
        paddr = '0;
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        ex_ok = 1'b0;
        if (!tag_valid || (tag_vpn != vaddr[ADDR_W-1:PAGE_BITS])) begin
            exc = miss_code;
        end else if (denied) begin
            exc = fault_code;
        end else begin
            exc   = EXC_NONE;
            paddr = {frame_pfn, vaddr[PAGE_BITS-1:0]};
            rd_ok = grant_r;
            wr_ok = grant_w;
            ex_ok = grant_x;
        end
    end

endmodule

// File: rtl/split_tlb_xlat.sv
module split_tlb_xlat
    import tlbx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    parameter int ENTRIES   = 64,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int VPN_W    = ADDR_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlat_en,
    input  logic              sup_mode,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              if_req,
    input  logic [ADDR_W-1:0] if_vaddr,
    input  logic              dc_req,
    input  logic              dc_write,
    input  logic [ADDR_W-1:0] dc_vaddr,
    output logic              if_rsp_valid,
    output logic [ADDR_W-1:0] if_paddr,
    output logic              if_exec_ok,
    output logic [2:0]        if_exc,
    output logic              dc_rsp_valid,
    output logic [ADDR_W-1:0] dc_paddr,
    output logic              dc_read_ok,
    output logic              dc_write_ok,
    output logic [2:0]        dc_exc,
    output logic [ADDR_W-1:0] fault_addr
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] pa;
        logic              r;
        logic              w;
        logic              x;
        tlb_exc_e          exc;
    } side_rsp_t;

    typedef struct packed {
        side_rsp_t         ir;
        side_rsp_t         dr;
        logic [ADDR_W-1:0] fa;
    } state_t;

    state_t st_d, st_q;

    // ---------------- tables ----------------
    logic [ADDR_W-1:0] i_tag, i_frame, d_tag, d_frame;
    logic [IDX_W-1:0]  if_idx, dc_idx;
    logic              i_we, d_we;

    assign if_idx = if_vaddr[PAGE_BITS +: IDX_W];
    assign dc_idx = dc_vaddr[PAGE_BITS +: IDX_W];
    assign i_we   = cfg_we && !cfg_sel[SEL_SIDE_BIT];
    assign d_we   = cfg_we &&  cfg_sel[SEL_SIDE_BIT];

    tlbx_table #(.ENTRIES(ENTRIES), .WORD_W(ADDR_W)) u_itab (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (i_we),
        .wr_frame (cfg_sel[SEL_WORD_BIT]),
        .wr_idx   (cfg_idx),
        .wr_data  (cfg_wdata),
        .rd_idx   (if_idx),
        .rd_tag   (i_tag),
        .rd_frame (i_frame)
    );

    tlbx_table #(.ENTRIES(ENTRIES), .WORD_W(ADDR_W)) u_dtab (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (d_we),
        .wr_frame (cfg_sel[SEL_WORD_BIT]),
        .wr_idx   (cfg_idx),
        .wr_data  (cfg_wdata),
        .rd_idx   (dc_idx),
        .rd_tag   (d_tag),
        .rd_frame (d_frame)
    );

    logic unused_rd_bits;
    assign unused_rd_bits = ^{i_tag[PAGE_BITS-1:1], d_tag[PAGE_BITS-1:1],
                              i_frame[PAGE_BITS-1:RB_USR_WR+1], i_frame[RB_SUP_RD-1:0],
                              d_frame[PAGE_BITS-1:RB_USR_WR+1], d_frame[RB_SUP_RD-1:0]};

    // ---------------- per-side checks ----------------
    logic [ADDR_W-1:0] ip_pa, dp_pa;
    logic              ip_r, ip_w, ip_x, dp_r, dp_w, dp_x;
    tlb_exc_e          ip_exc, dp_exc;

    tlbx_probe #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IS_CODE(1'b1)) u_iprobe (
        .vaddr     (if_vaddr),
        .tag_vpn   (i_tag[ADDR_W-1:PAGE_BITS]),
        .tag_valid (i_tag[0]),
        .frame_pfn (i_frame[ADDR_W-1:PAGE_BITS]),
        .perm      (i_frame[RB_USR_WR:RB_SUP_RD]),
        .sup       (sup_mode),
        .is_write  (1'b0),
        .paddr     (ip_pa),
        .rd_ok     (ip_r),
        .wr_ok     (ip_w),
        .ex_ok     (ip_x),
        .exc       (ip_exc)
    );

    tlbx_probe #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IS_CODE(1'b0)) u_dprobe (
        .vaddr     (dc_vaddr),
        .tag_vpn   (d_tag[ADDR_W-1:PAGE_BITS]),
        .tag_valid (d_tag[0]),
        .frame_pfn (d_frame[ADDR_W-1:PAGE_BITS]),
        .perm      (d_frame[RB_USR_WR:RB_SUP_RD]),
        .sup       (sup_mode),
        .is_write  (dc_write),
        .paddr     (dp_pa),
        .rd_ok     (dp_r),
        .wr_ok     (dp_w),
        .ex_ok     (dp_x),
        .exc       (dp_exc)
    );

    logic unused_probe_bits;
    assign unused_probe_bits = ip_r ^ ip_w ^ dp_x;

    // ---------------- next state ----------------
    always_comb begin
        st_d    = st_q;
        st_d.ir = '0;
        st_d.dr = '0;

        if (if_req) begin
            st_d.ir.vld = 1'b1;
            if (!xlat_en) begin
                st_d.ir.pa = if_vaddr;
                st_d.ir.x  = 1'b1;
            end else begin
                st_d.ir.pa  = ip_pa;
                st_d.ir.x   = ip_x;
                st_d.ir.exc = ip_exc;
            end
        end

        if (dc_req) begin
            st_d.dr.vld = 1'b1;
            if (!xlat_en) begin
                st_d.dr.pa = dc_vaddr;
                st_d.dr.r  = 1'b1;
                st_d.dr.w  = 1'b1;
            end else begin
                st_d.dr.pa  = dp_pa;
                st_d.dr.r   = dp_r;
                st_d.dr.w   = dp_w;
                st_d.dr.exc = dp_exc;
            end
        end

        // data fault outranks instruction fault for the shared register
        if (st_d.dr.exc != EXC_NONE)      st_d.fa = dc_vaddr;
        else if (st_d.ir.exc != EXC_NONE) st_d.fa = if_vaddr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign if_rsp_valid = st_q.ir.vld;
    assign if_paddr     = st_q.ir.pa;
    assign if_exec_ok   = st_q.ir.x;
    assign if_exc       = st_q.ir.exc;
    assign dc_rsp_valid = st_q.dr.vld;
    assign dc_paddr     = st_q.dr.pa;
    assign dc_read_ok   = st_q.dr.r;
    assign dc_write_ok  = st_q.dr.w;
    assign dc_exc       = st_q.dr.exc;
    assign fault_addr   = st_q.fa;

    // ---------------- assertions ----------------
    p_if_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        if_req |=> if_rsp_valid);
    p_dc_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dc_req |=> !dc_rsp_valid);
    p_bypass_identity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_req && !xlat_en) |=> (dc_paddr == $past(dc_vaddr) && dc_read_ok
                                  && dc_write_ok && dc_exc == EXC_NONE));
    p_miss_no_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_exc == EXC_DMISS) |-> (!dc_read_ok && !dc_write_ok && dc_paddr == '0));
    p_ifault_no_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (if_exc == EXC_IPF) |-> !if_exec_ok);
    p_offset_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (if_rsp_valid && if_exc == EXC_NONE)
            |-> (if_paddr[PAGE_BITS-1:0] == $past(if_vaddr[PAGE_BITS-1:0])));
    p_fault_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_rsp_valid && dc_exc != EXC_NONE) |-> (fault_addr == $past(dc_vaddr)));
    p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (if_exc == EXC_NONE && dc_exc == EXC_NONE) |-> $stable(fault_addr));

endmodule

// File: tb/tb_split_tlb_xlat.sv
module tb_split_tlb_xlat;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int PB = 13;
    localparam int NE = 64;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xlat_en = 1'b0, sup_mode = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          if_req = 1'b0, dc_req = 1'b0, dc_write = 1'b0;
    logic [AW-1:0] if_vaddr = '0, dc_vaddr = '0;
    logic          if_rsp_valid, if_exec_ok, dc_rsp_valid, dc_read_ok, dc_write_ok;
    logic [AW-1:0] if_paddr, dc_paddr, fault_addr;
    logic [2:0]    if_exc, dc_exc;

    split_tlb_xlat dut (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .sup_mode(sup_mode),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .if_req(if_req), .if_vaddr(if_vaddr),
        .dc_req(dc_req), .dc_write(dc_write), .dc_vaddr(dc_vaddr),
        .if_rsp_valid(if_rsp_valid), .if_paddr(if_paddr), .if_exec_ok(if_exec_ok),
        .if_exc(if_exc), .dc_rsp_valid(dc_rsp_valid), .dc_paddr(dc_paddr),
        .dc_read_ok(dc_read_ok), .dc_write_ok(dc_write_ok), .dc_exc(dc_exc),
        .fault_addr(fault_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [AW-1:0] m_itag [NE], m_ifrm [NE], m_dtag [NE], m_dfrm [NE];
    logic [AW-1:0] exp_fa = '0;

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        for (int i = 0; i < NE; i++) begin
            m_itag[i][0] = 1'b0;
            m_dtag[i][0] = 1'b0;
        end
        exp_fa = '0;
    endtask

    // R10: sel bit1 = table (0 instr, 1 data), bit0 = word (0 tag, 1 frame)
    task automatic cfg_write(input bit side, input bit frm, input int idx, input logic [AW-1:0] w);
        cfg_we = 1'b1; cfg_sel = {side, frm}; cfg_idx = IW'(idx); cfg_wdata = w;
        step();
        cfg_we = 1'b0;
        case ({side, frm})
            2'b00: m_itag[idx] = w;
            2'b01: m_ifrm[idx] = w;
            2'b10: m_dtag[idx] = w;
            default: m_dfrm[idx] = w;
        endcase
    endtask

    function automatic void exp_code(input logic [AW-1:0] va, input logic sup, input logic en,
                                     output logic [AW-1:0] pa, output logic x, output logic [2:0] e);
        int idx = int'(va[PB +: IW]);
        logic g;
        pa = '0; x = 1'b0; e = 3'd0;
        if (!en) begin pa = va; x = 1'b1; end
        else if (!m_itag[idx][0] || m_itag[idx][AW-1:PB] != va[AW-1:PB]) e = 3'd1;
        else begin
            g = sup ? m_ifrm[idx][6] : m_ifrm[idx][7];
            if (!g) e = 3'd3;
            else begin pa = {m_ifrm[idx][AW-1:PB], va[PB-1:0]}; x = 1'b1; end
        end
    endfunction

    function automatic void exp_data(input logic [AW-1:0] va, input logic sup, input logic en,
                                     input logic wr, output logic [AW-1:0] pa,
                                     output logic r, output logic w, output logic [2:0] e);
        int idx = int'(va[PB +: IW]);
        logic gr, gw;
        pa = '0; r = 1'b0; w = 1'b0; e = 3'd0;
        if (!en) begin pa = va; r = 1'b1; w = 1'b1; end
        else if (!m_dtag[idx][0] || m_dtag[idx][AW-1:PB] != va[AW-1:PB]) e = 3'd2;
        else begin
            gr = sup ? m_dfrm[idx][6] : m_dfrm[idx][8];
            gw = sup ? m_dfrm[idx][7] : m_dfrm[idx][9];
            if (wr ? !gw : !gr) e = 3'd4;
            else begin pa = {m_dfrm[idx][AW-1:PB], va[PB-1:0]}; r = gr; w = gw; end
        end
    endfunction

    task automatic lookup(input string tag, input bit di, input logic [AW-1:0] iva,
                          input bit dd, input logic [AW-1:0] dva, input logic wr);
        logic [AW-1:0] ipa, dpa;
        logic ix, dr, dw;
        logic [2:0] ie, de;
        exp_code(iva, sup_mode, xlat_en, ipa, ix, ie);
        exp_data(dva, sup_mode, xlat_en, wr, dpa, dr, dw, de);
        if_req = di; if_vaddr = iva; dc_req = dd; dc_vaddr = dva; dc_write = wr;
        if (dd && de != 0)      exp_fa = dva;
        else if (di && ie != 0) exp_fa = iva;
        step();
        if_req = 1'b0; dc_req = 1'b0;
        chk({tag, " R2 if_valid"}, AW'(if_rsp_valid), AW'(di));
        chk({tag, " R2 dc_valid"}, AW'(dc_rsp_valid), AW'(dd));
        if (di) begin
            chk({tag, " if_paddr"}, if_paddr, ipa);
            chk({tag, " if_exec"}, AW'(if_exec_ok), AW'(ix));
            chk({tag, " if_exc"}, AW'(if_exc), AW'(ie));
        end
        if (dd) begin
            chk({tag, " dc_paddr"}, dc_paddr, dpa);
            chk({tag, " dc_rd"}, AW'(dc_read_ok), AW'(dr));
            chk({tag, " dc_wr"}, AW'(dc_write_ok), AW'(dw));
            chk({tag, " dc_exc"}, AW'(dc_exc), AW'(de));
        end
        chk({tag, " R9 fault_addr"}, fault_addr, exp_fa);
    endtask

    function automatic logic [AW-1:0] mk_tag(input logic [AW-PB-1:0] vpn, input bit v);
        return {vpn, 12'h0, v};
    endfunction

    initial begin
        logic [AW-PB-1:0] vpn;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NE; i++) begin
            m_itag[i] = '0; m_ifrm[i] = '0; m_dtag[i] = '0; m_dfrm[i] = '0;
        end
        do_reset();

        // R1: reset state
        chk("R1 if_valid", AW'(if_rsp_valid), '0);
        chk("R1 dc_exc", AW'(dc_exc), '0);
        chk("R1 fault_addr", fault_addr, '0);
        xlat_en = 1'b1; sup_mode = 1'b1;
        lookup("R1 empty miss", 1, 32'h0000_4000, 1, 32'h1234_0000, 0);

        // R3 + R11: bypass on both sides at once
        xlat_en = 1'b0;
        lookup("R3 bypass", 1, 32'hDEAD_BEEF, 1, 32'h0BAD_F00D, 1);
        xlat_en = 1'b1;

        // R6/R8/R10: instr entry index 5, supervisor exec only
        vpn = {13'h0A5A, 6'd5};
        cfg_write(0, 0, 5, mk_tag(vpn, 1));
        cfg_write(0, 1, 5, {19'h3_1234, 13'h0040});
        sup_mode = 1'b1;
        lookup("R8 ihit sup", 1, {vpn, 13'h1ABC}, 0, '0, 0);
        sup_mode = 1'b0;
        lookup("R6 ipf user", 1, {vpn, 13'h0007}, 0, '0, 0);
        // R5: tag matches but valid clear
        cfg_write(0, 0, 5, mk_tag(vpn, 0));
        sup_mode = 1'b1;
        lookup("R5 invalid", 1, {vpn, 13'h0010}, 0, '0, 0);

        // R7: data entry index 9, sup read + user write
        vpn = {13'h1111, 6'd9};
        cfg_write(1, 0, 9, mk_tag(vpn, 1));
        cfg_write(1, 1, 9, {19'h7_0F0F, 13'h0240});
        sup_mode = 1'b1;
        lookup("R7 sup read ok", 0, '0, 1, {vpn, 13'h0100}, 0);
        lookup("R7 sup write dpf", 0, '0, 1, {vpn, 13'h0104}, 1);
        sup_mode = 1'b0;
        lookup("R7 user write ok", 0, '0, 1, {vpn, 13'h0108}, 1);
        lookup("R7 user read dpf", 0, '0, 1, {vpn, 13'h010C}, 0);
        // R4: same index, other page
        lookup("R4 vpn mismatch", 0, '0, 1, {13'h0222, 6'd9, 13'h0}, 0);

        // R9: both sides fault, data address wins; then clean lookup holds
        lookup("R9 dual fault", 1, 32'h7777_0000, 1, 32'h5555_0000, 0);
        sup_mode = 1'b0;
        lookup("R9 hold", 0, '0, 1, {vpn, 13'h0200}, 1);
        // R2: idle cycle
        lookup("R2 idle", 0, '0, 0, '0, 0);

        // R1: reset drops a live entry
        do_reset();
        xlat_en = 1'b1;
        lookup("R1 after reset", 0, '0, 1, {vpn, 13'h0200}, 1);

        // random mix (R4 R5 R6 R7 R8 R11)
        for (int it = 0; it < 600; it++) begin
            int idx;
            logic [AW-1:0] iva, dva;
            if ($urandom_range(0, 2) == 0) begin
                idx = $urandom_range(0, NE-1);
                vpn = {13'($urandom), 6'(idx)};
                cfg_write(1'($urandom), 0, idx, mk_tag(vpn, $urandom_range(0, 3) != 0));
                cfg_write(1'($urandom), 1, idx, $urandom);
            end
            xlat_en  = ($urandom_range(0, 7) != 0);
            sup_mode = 1'($urandom);
            idx = $urandom_range(0, NE-1);
            iva = ($urandom_range(0, 3) != 0) ? {m_itag[idx][AW-1:PB], 13'($urandom)} : $urandom;
            idx = $urandom_range(0, NE-1);
            dva = ($urandom_range(0, 3) != 0) ? {m_dtag[idx][AW-1:PB], 13'($urandom)} : $urandom;
            lookup("R11 random", 1'($urandom), iva, 1'($urandom), dva, 1'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule